// File: doc/BRIEF.md
# DDS Phase Accumulator With Offset

This block is the phase engine of a direct digital synthesizer. On every clock it adds a 32-bit frequency tuning word to a 32-bit accumulator. It then adds a 14-bit phase offset to the top 14 accumulator bits, and the result is the phase word for a downstream phase-to-amplitude converter. A fixed offset shifts the waveform by a constant angle. Rewriting the offset again and again gives phase modulation, at a rate set by how often new values arrive.

The tuning word, offset and two clear controls arrive as staged values. They are copied into the active registers only when the update strobe is high. A level-held clear keeps the accumulator at zero for as long as its active bit is set. When the auto-clear bit is set, each update strobe zeroes the accumulator once and then lets it run again.

Top module: `dds_phase_acc`

## Requirements
- R1: While `rst_n` is low, the accumulator and all active registers are zero, so `phase_out` reads 0.
- R2: On each clock edge without a clear, the accumulator adds the active tuning word modulo 2^32 and sets no overflow flag. `phase_out` is taken from accumulator bits [31:18].
- R3: `phase_out` equals accumulator bits [31:18] plus the active offset, modulo 2^14.
- R4: Changes to `ftw_in`, `poff_in`, `hold_clr_in` or `auto_clr_in` have no effect on `phase_out` unless `upd_strobe` is high.
- R5: On the edge where `upd_strobe` is high, the staged values govern that edge: the accumulator adds the new tuning word, and the new offset appears in `phase_out` right after the edge.
- R6: While the active continuous-clear bit is 1, the accumulator stays at zero, so `phase_out` equals the active offset.
- R7: After the continuous clear is removed by a strobe, accumulation restarts from zero with the active tuning word.
- R8: A strobe with `auto_clr_in`=1 zeroes the accumulator on that edge, and accumulation resumes on the next edge. Every later strobe with the bit still set does the same.
- R9: When both clears apply, the continuous clear wins: the accumulator stays at zero, even on edges after an auto-clear strobe.
- R10: A strobe with `auto_clr_in`=0 and `hold_clr_in`=0 does not disturb the accumulator, which keeps adding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ftw_in | input | 32 | Staged frequency tuning word |
| poff_in | input | 14 | Staged phase offset |
| hold_clr_in | input | 1 | Staged continuous-clear bit |
| auto_clr_in | input | 1 | Staged auto-clear bit |
| upd_strobe | input | 1 | Copies the staged values into the active registers |
| phase_out | output | 14 | Offset phase word |

## Verification
On every cycle, the assertions check three things: the active registers stay stable between strobes, the accumulator step matches the active tuning word when no clear applies, and the output equals the offset under either clear. Other behaviours appear only over a sequence of cycles, so only the bench scenarios can show them. These are wraparound of the accumulator and of the offset sum, restart after the continuous clear is released, and repeated auto-clears over a series of strobes. The bench runs all of these against a cycle-accurate model.

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] ftw_in,
  input  logic [PH_W-1:0]  poff_in,
  input  logic             hold_clr_in,
  input  logic             auto_clr_in,
  input  logic             upd_strobe,
  output logic [PH_W-1:0]  phase_out
);
  localparam int TOP_LSB = ACC_W - PH_W;

  logic [ACC_W-1:0] acc_q, ftw_q;
  logic [PH_W-1:0]  poff_q;
  logic             hold_q, auto_q;

  logic [ACC_W-1:0] ftw_eff;
  logic             hold_eff, clr_now;

  assign ftw_eff  = upd_strobe ? ftw_in : ftw_q;
  assign hold_eff = upd_strobe ? hold_clr_in : hold_q;
  assign clr_now  = hold_eff | (upd_strobe & auto_clr_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ftw_q  <= '0;
      poff_q <= '0;
      hold_q <= 1'b0;
      auto_q <= 1'b0;
    end else if (upd_strobe) begin
      ftw_q  <= ftw_in;
      poff_q <= poff_in;
      hold_q <= hold_clr_in;
      auto_q <= auto_clr_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (clr_now) acc_q <= '0;
    else              acc_q <= acc_q + ftw_eff;
  end

  assign phase_out = acc_q[ACC_W-1:TOP_LSB] + poff_q;

  // R4
  active_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_strobe |=> ($stable(ftw_q) && $stable(poff_q) && $stable(hold_q) && $stable(auto_q)));

  // R2
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_strobe && !hold_q) |=> (acc_q == $past(acc_q) + $past(ftw_q)));

  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> (phase_out == poff_q));

  // R8
  auto_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_strobe && auto_clr_in) |=> (phase_out == poff_q && acc_q == '0));

  // R5
  strobe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |=> (poff_q == $past(poff_in) && auto_q == $past(auto_clr_in)));
endmodule

// File: tb/test_dds_phase_acc.sv
module test_dds_phase_acc;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ftw_in = '0;
  logic [13:0] poff_in = '0;
  logic        hold_clr_in = 1'b0;
  logic        auto_clr_in = 1'b0;
  logic        upd_strobe = 1'b0;
  logic [13:0] phase_out;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  bit chk_en = 1'b0;
  string tag = "R1";

  logic [31:0] m_acc = '0, m_ftw = '0;
  logic [13:0] m_poff = '0;
  logic        m_hold = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dds_phase_acc i_dds_phase_acc (
    .clk(clk), .rst_n(rst_n), .ftw_in(ftw_in), .poff_in(poff_in),
    .hold_clr_in(hold_clr_in), .auto_clr_in(auto_clr_in),
    .upd_strobe(upd_strobe), .phase_out(phase_out)
  );

  function automatic logic [13:0] exp_phase(logic [31:0] a, logic [13:0] o);
    return a[31:18] + o;
  endfunction

  always @(posedge clk) begin
    logic [31:0] f;
    logic h;
    if (!rst_n) begin
      m_acc <= '0; m_ftw <= '0; m_poff <= '0; m_hold <= 1'b0;
    end else begin
      f = upd_strobe ? ftw_in : m_ftw;
      h = upd_strobe ? hold_clr_in : m_hold;
      if (h || (upd_strobe && auto_clr_in)) m_acc <= '0;
      else m_acc <= m_acc + f;
      if (upd_strobe) begin
        m_ftw <= ftw_in; m_poff <= poff_in; m_hold <= hold_clr_in;
      end
    end
  end

  task automatic check(string t, logic [13:0] act, logic [13:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: phase_out=%h expected=%h", t, act, exp);
    end
  endtask

  always @(negedge clk)
    if (chk_en && !done) check(tag, phase_out, exp_phase(m_acc, m_poff));

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(logic [31:0] f, logic [13:0] o, logic h, logic a);
    ftw_in = f; poff_in = o; hold_clr_in = h; auto_clr_in = a;
    upd_strobe = 1'b1;
    @(negedge clk);
    upd_strobe = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    cyc(3);
    check("R1", phase_out, 14'h0);
    rst_n = 1'b1;
    chk_en = 1'b1;

    tag = "R2"; strobe(32'h0004_0000, 14'h0, 0, 0); cyc(20);
    tag = "R2"; strobe(32'hFFFF_FFFF, 14'h0, 0, 0); cyc(20);
    tag = "R3"; strobe(32'h0123_4567, 14'h3FFF, 0, 0); cyc(30);
    tag = "R4";
    ftw_in = 32'h7000_0000; poff_in = 14'h1555; hold_clr_in = 1; auto_clr_in = 1;
    cyc(10);
    tag = "R5"; strobe(32'h0010_0000, 14'h0200, 0, 0); cyc(5);
    tag = "R6"; strobe(32'h0800_0000, 14'h0ABC, 1, 0); cyc(10);
    check("R6", phase_out, 14'h0ABC);
    tag = "R7"; strobe(32'h0800_0000, 14'h0ABC, 0, 0); cyc(10);
    tag = "R8"; strobe(32'h0300_0000, 14'h0011, 0, 1);
    check("R8", phase_out, 14'h0011);
    cyc(7);
    strobe(32'h0300_0000, 14'h0022, 0, 1);
    check("R8", phase_out, 14'h0022);
    cyc(7);
    tag = "R9"; strobe(32'h0300_0000, 14'h0033, 1, 1); cyc(5);
    check("R9", phase_out, 14'h0033);
    tag = "R10"; strobe(32'h0300_0000, 14'h0044, 0, 0); cyc(6);
    strobe(32'h0500_0000, 14'h0044, 0, 0); cyc(6);

    tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      ftw_in = $urandom; poff_in = 14'($urandom);
      hold_clr_in = ($urandom % 10) == 0;
      auto_clr_in = ($urandom % 3) == 0;
      upd_strobe = ($urandom % 6) == 0;
      @(negedge clk);
    end
    upd_strobe = 1'b0;
    cyc(2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule